// File: doc/BRIEF.md
# Radio Serial Control Word Loader

This block writes control words into two serial targets that share one clock line and one data line: the radio's frequency synthesizer and a serial DAC that sets transmit power and the receive signal-strength threshold. Each target has its own active-low load line. The load line of the chosen target goes low for the whole shift. Its rising edge after the last bit tells the target to take the word.

A requester presents a word and a bit count on one of two request channels, one per target. The block answers with `busy` for as long as the transfer runs and with a one-cycle `done` when the load line returns high. The serial clock runs at half the block clock. Words go out most significant bit first, and only the low-order bits selected by the count are sent. Transfers never overlap. A request that arrives while the block is busy is dropped, and so is a synthesizer request made while the radio is not idle. When both channels ask in the same cycle, the DAC request wins and the synthesizer request is dropped.

Top module: `rf_serial_loader`

## Requirements
- R1: While reset is held and in the first cycle after it, `ser_clk`=0, `ser_data`=0, `syn_load_n`=1, `dac_load_n`=1, `busy`=0 and `done`=0.
- R2: During a transfer `ser_clk` is low for one cycle and then high for one cycle, once per bit, so it runs at half the clock rate. The first high cycle is the second cycle after the request is accepted. The number of high pulses equals the bit count.
- R3: Bits are sent from bit (len-1) of the request word down to bit 0. Word bits at or above len have no effect.
- R4: `ser_data` changes only at clock edges where `ser_clk` falls or stays low. It never changes at an edge where `ser_clk` rises.
- R5: The chosen target's load line is low from the cycle after acceptance through the cycle after the last `ser_clk` high, so it stays low for 2*len+1 cycles. It rises in the next cycle.
- R6: `done` is 1 for exactly one cycle: the cycle in which the load line has just risen. `busy` is 1 from the cycle after acceptance through that `done` cycle, 2*len+2 cycles in total.
- R7: A request is accepted only at a clock edge where `busy` is 0. A request made while `busy` is 1 is dropped and does not start a later transfer.
- R8: A synthesizer request is dropped when `radio_idle` is 0 at the accepting edge.
- R9: When valid DAC and synthesizer requests arrive at the same edge, only the DAC transfer runs. The synthesizer request is dropped.
- R10: A request with len=0 or len greater than 24 is dropped.
- R11: At most one load line is low at any time. `ser_clk` and `ser_data` are 0 whenever `busy` is 0.
- R12: A synthesizer word of the full 24 bits is sent completely, from bit 23 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (radio clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| radio_idle | input | 1 | High when the radio is neither receiving nor transmitting |
| syn_req | input | 1 | Synthesizer write request, sampled each edge |
| syn_word | input | 24 | Synthesizer word; low `syn_len` bits are sent |
| syn_len | input | 5 | Synthesizer bit count, 1 to 24 |
| dac_req | input | 1 | DAC write request, sampled each edge |
| dac_word | input | 24 | DAC word; low `dac_len` bits are sent |
| dac_len | input | 5 | DAC bit count, 1 to 24 |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when the load line returns high |
| ser_clk | output | 1 | Shared serial clock |
| ser_data | output | 1 | Shared serial data |
| syn_load_n | output | 1 | Synthesizer load line, active low |
| dac_load_n | output | 1 | DAC load line, active low |

## Verification
The assertions assume that all request inputs are synchronous to `clk` and stable at the rising edge. They also assume that `radio_idle` is a clean level, so that a low-going synthesizer load line can be traced back to `radio_idle` being high one cycle earlier. The bench respects this by changing every input only at falling clock edges. Each request is held for exactly one cycle, because requests are not queued. Requests made while the block is busy, or with the radio not idle, are placed on purpose so that they land on an edge with known outcome.

// File: rtl/rfsl_pkg.sv
// Package: shared types and target codes for the serial control word loader.
// Assumes two targets; the code of each target selects its load line.
package rfsl_pkg;
    typedef enum logic [1:0] {
        SH_IDLE   = 2'd0,
        SH_SHIFT  = 2'd1,
        SH_TAIL   = 2'd2,
        SH_STROBE = 2'd3
    } shift_state_t;

    localparam int NUM_TGT = 2;
    localparam int TGT_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;
    localparam int TGT_SYN = 0;
    localparam int TGT_DAC = 1;
endpackage

// File: rtl/rfsl_arbiter.sv
// Module: rfsl_arbiter
// Picks at most one request per cycle. The DAC channel has priority. A
// synthesizer request needs the radio idle, and both channels need a bit
// count of 1..WORD_W.
// Assumes: free is high only when no transfer is running.
module rfsl_arbiter #(
    parameter int WORD_W = 24,
    parameter int LEN_W  = $clog2(WORD_W + 1)
) (
    input  logic                        free,
    input  logic                        radio_idle,
    input  logic                        syn_req,
    input  logic [WORD_W-1:0]           syn_word,
    input  logic [LEN_W-1:0]            syn_len,
    input  logic                        dac_req,
    input  logic [WORD_W-1:0]           dac_word,
    input  logic [LEN_W-1:0]            dac_len,
    output logic                        grant,
    output logic [rfsl_pkg::TGT_W-1:0]  grant_tgt,
    output logic [WORD_W-1:0]           grant_word,
    output logic [LEN_W-1:0]            grant_len
);
    import rfsl_pkg::*;

    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(WORD_W);

    logic syn_ok, dac_ok;

    // Qualify each channel: length range, and radio idle for the synthesizer.
    always_comb begin
        dac_ok = dac_req && (dac_len != '0) && (dac_len <= MAX_LEN);
        syn_ok = syn_req && radio_idle && (syn_len != '0) && (syn_len <= MAX_LEN);
    end

    // Fixed priority selection: DAC first, then synthesizer.
    always_comb begin
        grant = free && (dac_ok || syn_ok);
        if (dac_ok) begin
            grant_tgt  = TGT_W'(TGT_DAC);
            grant_word = dac_word;
            grant_len  = dac_len;
        end else begin
            grant_tgt  = TGT_W'(TGT_SYN);
            grant_word = syn_word;
            grant_len  = syn_len;
        end
    end
endmodule

// File: rtl/rfsl_shifter.sv
// Module: rfsl_shifter
// Serializes one word MSB first. The serial clock toggles each cycle, and the
// data changes only with the falling serial clock. A tail cycle keeps the
// frame open after the last bit, and then a strobe cycle marks the latch.
// Assumes: start is raised only while busy is low.
module rfsl_shifter #(
    parameter int WORD_W = 24,
    parameter int LEN_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    input  logic [LEN_W-1:0]  len,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              frame_active,
    output logic              strobe,
    output logic              busy
);
    import rfsl_pkg::*;

    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(WORD_W);

    shift_state_t      st;
    logic              sclk_q;
    logic [WORD_W-1:0] shreg;
    logic [LEN_W-1:0]  bits_left;

    // Sequencer: load a left-aligned word, toggle the clock, shift on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SH_IDLE;
            sclk_q    <= 1'b0;
            shreg     <= '0;
            bits_left <= '0;
        end else begin
            case (st)
                SH_IDLE: begin
                    if (start) begin
                        st        <= SH_SHIFT;
                        shreg     <= word << (MAX_LEN - len);
                        bits_left <= len;
                        sclk_q    <= 1'b0;
                    end
                end
                SH_SHIFT: begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        if (bits_left == LEN_W'(1)) begin
                            st <= SH_TAIL;
                        end else begin
                            shreg     <= shreg << 1;
                            bits_left <= bits_left - LEN_W'(1);
                        end
                    end
                end
                SH_TAIL:   st <= SH_STROBE;
                SH_STROBE: st <= SH_IDLE;
                default:   st <= SH_IDLE;
            endcase
        end
    end

    // Output decode from registered state only.
    always_comb begin
        ser_clk      = sclk_q;
        ser_data     = (st == SH_SHIFT) && shreg[WORD_W-1];
        frame_active = (st == SH_SHIFT) || (st == SH_TAIL);
        strobe       = (st == SH_STROBE);
        busy         = (st != SH_IDLE);
    end

    // Checker state: counts the serial clock rises of the current frame.
    logic [LEN_W-1:0] rise_cnt;
    logic [LEN_W-1:0] len_chk;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt <= '0;
            len_chk  <= '0;
        end else if (st == SH_IDLE && start) begin
            rise_cnt <= '0;
            len_chk  <= len;
        end else if (st == SH_SHIFT && !sclk_q) begin
            rise_cnt <= rise_cnt + LEN_W'(1);
        end
    end

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data));
    assert_clk_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |=> !ser_clk);
    assert_clk_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> frame_active);
    assert_bit_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (rise_cnt == len_chk));
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
endmodule

// File: rtl/rfsl_load_ctl.sv
// Module: rfsl_load_ctl
// Remembers which target owns the current frame and drives one active-low
// load line per target. Only the owner's line goes low while the frame is open.
// Assumes: start is raised only when no frame is open.
module rfsl_load_ctl #(
    parameter int NUM_TGT = rfsl_pkg::NUM_TGT,
    parameter int TGT_W   = rfsl_pkg::TGT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [TGT_W-1:0]   start_tgt,
    input  logic               frame_active,
    output logic [NUM_TGT-1:0] load_n
);
    logic [TGT_W-1:0] tgt_q;

    // Capture the owner of the frame when a transfer is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else if (start) begin
            tgt_q <= start_tgt;
        end
    end

    // One load line per target.
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_load
        assign load_n[t] = !(frame_active && (tgt_q == TGT_W'(t)));
    end

    assert_single_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~load_n));
    assert_owner_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && $past(frame_active)) |-> $stable(tgt_q));
endmodule

// File: rtl/rf_serial_loader.sv
// Module: rf_serial_loader (top)
// Serial control word loader for a synthesizer and a serial DAC that share
// one clock and one data line and have separate active-low load lines.
// Assumes: all inputs are synchronous to clk, and requests are not held by
// the block (a request that is not granted is dropped).
module rf_serial_loader #(
    parameter int WORD_W = 24,
    parameter int LEN_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              radio_idle,
    input  logic              syn_req,
    input  logic [WORD_W-1:0] syn_word,
    input  logic [LEN_W-1:0]  syn_len,
    input  logic              dac_req,
    input  logic [WORD_W-1:0] dac_word,
    input  logic [LEN_W-1:0]  dac_len,
    output logic              busy,
    output logic              done,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              syn_load_n,
    output logic              dac_load_n
);
    import rfsl_pkg::*;

    logic                  grant;
    logic [TGT_W-1:0]      grant_tgt;
    logic [WORD_W-1:0]     grant_word;
    logic [LEN_W-1:0]      grant_len;
    logic                  frame_active;
    logic                  sh_busy;
    logic [NUM_TGT-1:0]    load_n;

    rfsl_arbiter #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_arb (
        .free       (!sh_busy),
        .radio_idle (radio_idle),
        .syn_req    (syn_req),
        .syn_word   (syn_word),
        .syn_len    (syn_len),
        .dac_req    (dac_req),
        .dac_word   (dac_word),
        .dac_len    (dac_len),
        .grant      (grant),
        .grant_tgt  (grant_tgt),
        .grant_word (grant_word),
        .grant_len  (grant_len)
    );

    rfsl_shifter #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (grant),
        .word         (grant_word),
        .len          (grant_len),
        .ser_clk      (ser_clk),
        .ser_data     (ser_data),
        .frame_active (frame_active),
        .strobe       (done),
        .busy         (sh_busy)
    );

    rfsl_load_ctl #(.NUM_TGT(NUM_TGT), .TGT_W(TGT_W)) u_load (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (grant),
        .start_tgt    (grant_tgt),
        .frame_active (frame_active),
        .load_n       (load_n)
    );

    // Map the per-target load lines to named ports.
    always_comb begin
        busy       = sh_busy;
        syn_load_n = load_n[TGT_SYN];
        dac_load_n = load_n[TGT_DAC];
    end

    assert_syn_needs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(syn_load_n) |-> $past(radio_idle));
    assert_start_when_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(syn_load_n) || $fell(dac_load_n)) |-> $past(!busy));
    assert_done_at_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (syn_load_n && dac_load_n && $past(!syn_load_n || !dac_load_n)));
    assert_lines_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_clk && !ser_data));
endmodule

// File: tb/sim_rf_serial_loader.sv
// Bench for rf_serial_loader: a behavioural per-cycle reference model is
// compared on every clock, and a line monitor rebuilds the latched words.
module sim_rf_serial_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        radio_idle = 1'b1;
    logic        syn_req = 1'b0;
    logic [23:0] syn_word = '0;
    logic [4:0]  syn_len = '0;
    logic        dac_req = 1'b0;
    logic [23:0] dac_word = '0;
    logic [4:0]  dac_len = '0;
    logic        busy, done, ser_clk, ser_data, syn_load_n, dac_load_n;

    always #2 clk = ~clk;

    rf_serial_loader u0 (
        .clk(clk), .rst_n(rst_n), .radio_idle(radio_idle),
        .syn_req(syn_req), .syn_word(syn_word), .syn_len(syn_len),
        .dac_req(dac_req), .dac_word(dac_word), .dac_len(dac_len),
        .busy(busy), .done(done), .ser_clk(ser_clk), .ser_data(ser_data),
        .syn_load_n(syn_load_n), .dac_load_n(dac_load_n)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct packed {
        logic busy; logic done; logic sclk; logic sdata; logic syn_n; logic dac_n;
    } exp_t;
    localparam exp_t IDLE_E = '{busy:1'b0, done:1'b0, sclk:1'b0, sdata:1'b0, syn_n:1'b1, dac_n:1'b1};
    exp_t mq[$];
    exp_t cur = IDLE_E;
    bit   model_on = 1'b0;

    function automatic bit len_ok(input int l);
        return (l >= 1) && (l <= 24);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            cur = IDLE_E;
        end else begin
            if (!cur.busy) begin
                bit use_dac, use_syn;
                use_dac = dac_req && len_ok(int'(dac_len));
                use_syn = !use_dac && syn_req && radio_idle && len_ok(int'(syn_len));
                if (use_dac || use_syn) begin
                    int   l;
                    logic [23:0] w;
                    logic sn, dn;
                    l  = use_dac ? int'(dac_len) : int'(syn_len);
                    w  = use_dac ? dac_word : syn_word;
                    sn = use_dac;
                    dn = !use_dac;
                    for (int i = l - 1; i >= 0; i--) begin
                        mq.push_back('{busy:1'b1, done:1'b0, sclk:1'b0, sdata:w[i], syn_n:sn, dac_n:dn});
                        mq.push_back('{busy:1'b1, done:1'b0, sclk:1'b1, sdata:w[i], syn_n:sn, dac_n:dn});
                    end
                    mq.push_back('{busy:1'b1, done:1'b0, sclk:1'b0, sdata:1'b0, syn_n:sn, dac_n:dn});
                    mq.push_back('{busy:1'b1, done:1'b1, sclk:1'b0, sdata:1'b0, syn_n:1'b1, dac_n:1'b1});
                end
            end
            cur = (mq.size() > 0) ? mq.pop_front() : IDLE_E;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check(ser_clk == cur.sclk, "R2 ser_clk", int'(ser_clk), int'(cur.sclk));
            check(ser_data == cur.sdata, "R3 ser_data", int'(ser_data), int'(cur.sdata));
            check({syn_load_n, dac_load_n} == {cur.syn_n, cur.dac_n}, "R5 load lines",
                  int'({syn_load_n, dac_load_n}), int'({cur.syn_n, cur.dac_n}));
            check({busy, done} == {cur.busy, cur.done}, "R6 busy/done",
                  int'({busy, done}), int'({cur.busy, cur.done}));
        end
    end

    // ---------------- line monitor ----------------
    int   lat_tgt[$];
    int   lat_word[$];
    int   lat_bits[$];
    int   shbuf = 0, nbits = 0, cur_tgt = 0;
    int   hold_bad = 0, overlap_bad = 0, quiet_bad = 0;
    logic p_clk = 1'b0, p_data = 1'b0, p_syn = 1'b1, p_dac = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_data != p_data && ser_clk && !p_clk) hold_bad++;
            if (!syn_load_n && !dac_load_n) overlap_bad++;
            if (!busy && (ser_clk || ser_data)) quiet_bad++;
            if (p_syn && !syn_load_n) begin shbuf = 0; nbits = 0; cur_tgt = 0; end
            if (p_dac && !dac_load_n) begin shbuf = 0; nbits = 0; cur_tgt = 1; end
            if (ser_clk && !p_clk) begin shbuf = (shbuf << 1) | int'(ser_data); nbits++; end
            if ((!p_syn && syn_load_n) || (!p_dac && dac_load_n)) begin
                lat_tgt.push_back(cur_tgt);
                lat_word.push_back(shbuf);
                lat_bits.push_back(nbits);
            end
        end
        p_clk = ser_clk; p_data = ser_data; p_syn = syn_load_n; p_dac = dac_load_n;
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input bit s, input logic [23:0] sw, input int sl,
                         input bit d, input logic [23:0] dw, input int dl);
        @(negedge clk);
        syn_req = s; syn_word = sw; syn_len = 5'(sl);
        dac_req = d; dac_word = dw; dac_len = 5'(dl);
        @(negedge clk);
        syn_req = 1'b0; dac_req = 1'b0;
    endtask

    task automatic settle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_latch(input int idx, input int tgt, input int word, input int bits, input string tag);
        if (idx >= lat_tgt.size()) begin
            check(1'b0, {tag, " latch missing"}, lat_tgt.size(), idx + 1);
        end else begin
            check(lat_tgt[idx] == tgt, {tag, " target"}, lat_tgt[idx], tgt);
            check(lat_word[idx] == word, {tag, " word"}, lat_word[idx], word);
            check(lat_bits[idx] == bits, {tag, " bit count R2"}, lat_bits[idx], bits);
        end
    endtask

    task automatic clear_log();
        lat_tgt.delete(); lat_word.delete(); lat_bits.delete();
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check({ser_clk, ser_data, syn_load_n, dac_load_n, busy, done} == 6'b001100,
              "R1 reset outputs", int'({ser_clk, ser_data, syn_load_n, dac_load_n, busy, done}), 'h0c);
        @(negedge clk); rst_n = 1'b1; model_on = 1'b1;
        check({ser_clk, ser_data, syn_load_n, dac_load_n, busy, done} == 6'b001100,
              "R1 after release", int'({ser_clk, ser_data, syn_load_n, dac_load_n, busy, done}), 'h0c);

        // R12 / R3: full synthesizer word
        clear_log();
        drive(1, 24'hA5C3F1, 24, 0, 0, 0); settle();
        expect_latch(0, 0, 'hA5C3F1, 24, "R12 syn 24-bit");

        // R3: DAC 10-bit, upper word bits ignored
        clear_log();
        drive(0, 0, 0, 1, 24'hFFF2AB, 10); settle();
        expect_latch(0, 1, 'h2AB, 10, "R3 dac 10-bit low bits");

        // R3: DAC 12-bit pattern
        clear_log();
        drive(0, 0, 0, 1, 24'h000C35, 12); settle();
        expect_latch(0, 1, 'hC35, 12, "R3 dac 12-bit");

        // R2: single bit
        clear_log();
        drive(1, 24'hFFFFFF, 1, 0, 0, 0); settle();
        expect_latch(0, 0, 1, 1, "R2 one-bit word");

        // R8: synthesizer refused while radio busy
        clear_log();
        radio_idle = 1'b0;
        drive(1, 24'h123456, 24, 0, 0, 0); settle();
        check(lat_tgt.size() == 0, "R8 syn while radio active", lat_tgt.size(), 0);
        // DAC still served while radio active
        drive(0, 0, 0, 1, 24'h0003FF, 10); settle();
        expect_latch(0, 1, 'h3FF, 10, "R8 dac while radio active");
        radio_idle = 1'b1;

        // R9: simultaneous requests
        clear_log();
        drive(1, 24'h00BEEF, 16, 1, 24'h000555, 12); settle();
        check(lat_tgt.size() == 1, "R9 one transfer", lat_tgt.size(), 1);
        expect_latch(0, 1, 'h555, 12, "R9 dac first");

        // R7: request during busy is dropped
        clear_log();
        fork
            drive(0, 0, 0, 1, 24'h000ABC, 12);
            begin
                repeat (6) @(negedge clk);
                syn_req = 1'b1; syn_word = 24'h777777; syn_len = 5'd24;
                @(negedge clk);
                syn_req = 1'b0;
            end
        join
        settle();
        check(lat_tgt.size() == 1, "R7 busy request dropped", lat_tgt.size(), 1);
        expect_latch(0, 1, 'hABC, 12, "R7 first transfer intact");

        // R10: out-of-range lengths
        clear_log();
        drive(1, 24'h111111, 0, 0, 0, 0); settle();
        drive(0, 0, 0, 1, 24'h222222, 25); settle();
        drive(1, 24'h333333, 31, 0, 0, 0); settle();
        check(lat_tgt.size() == 0, "R10 bad length", lat_tgt.size(), 0);

        // Back-to-back request right after done
        clear_log();
        drive(1, 24'h0000A5, 8, 0, 0, 0);
        for (int i = 0; i < 100 && !done; i++) @(negedge clk);
        @(negedge clk);
        dac_req = 1'b1; dac_word = 24'h00003C; dac_len = 5'd6;
        @(negedge clk); dac_req = 1'b0;
        settle();
        expect_latch(0, 0, 'hA5, 8, "R5 first of pair");
        expect_latch(1, 1, 'h3C, 6, "R5 second of pair");

        check(hold_bad == 0, "R4 data change at rising ser_clk", hold_bad, 0);
        check(overlap_bad == 0, "R11 overlapping load lines", overlap_bad, 0);
        check(quiet_bad == 0, "R11 lines not quiet when idle", quiet_bad, 0);

        summary();
    end
endmodule